// File: doc/BRIEF.md
# Dual-Width Photon Count Bin Recorder

This block captures the shape of a scintillation pulse as a sequence of photon-count bins. Every clock cycle is one frame, and a summed count of fired detectors arrives on `frame_count`. While an event is being recorded, those per-frame counts are added into the current bin. When the bin's width in frames has elapsed, the bin is closed and written into an on-chip FIFO. A fresh bin then opens.

A single `event_start` pulse begins a recording. The first bins use a short width so that the fast leading part of the pulse is resolved finely. After a configured number of short bins, the block switches to a long width for the slow tail. Both parts go into the same FIFO. Recording ends after a configured total number of bins, and the block returns to idle.

The configuration is captured when the event starts. A host drains the FIFO through a first-word-fall-through read port. A sticky flag reports any bin that was lost because the FIFO was full.

Top module: `pulse_bin_fifo`

## Requirements
- R1: An `event_start` sampled high while idle starts recording. `busy` is high from the next cycle onward. The first counted frame is the cycle after the one in which `event_start` was sampled, and the count present during the start cycle itself is not counted.
- R2: A bin's value is the sum of `frame_count` over every frame of its width. The bin is written to the FIFO at the clock edge that samples its last frame.
- R3: The first `cfg_short_bins` bins of an event are each `cfg_short_len` frames wide, and every later bin is `cfg_long_len` frames wide. If `cfg_short_bins` is 0, all bins are long. If `cfg_short_bins` is at least `cfg_total_bins`, all bins are short.
- R4: Recording ends after `cfg_total_bins` bins. `busy` falls at the edge that writes the last bin, and frames presented after that produce no FIFO entry.
- R5: A width setting of 0 behaves as 1 frame. A total bin setting of 0 behaves as 1 bin.
- R6: A bin value saturates at 4095 (all ones of the 12-bit bin) instead of wrapping.
- R7: The four configuration inputs are captured at event start. Changing them during an event, or pulsing `event_start` while `busy` is high, has no effect on the bins of the running event.
- R8: The FIFO holds 128 bins in arrival order. `rd_data` shows the oldest entry whenever `fifo_empty` is low, and `rd_en` removes that entry at the next edge. `fifo_level` gives the entry count, and `fifo_full` is high at 128.
- R9: A bin written while the FIFO is full and no read occurs in the same cycle is discarded, and `overflow` is set and stays set until reset. A write and a read in the same cycle at full both take effect, so the level stays at 128.
- R10: After reset, `busy` and `overflow` are low, `fifo_empty` is high, `fifo_full` is low and `fifo_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock; one cycle per frame |
| rst | input | 1 | Synchronous active-high reset |
| frame_count | input | 8 | Summed detector count of the current frame |
| event_start | input | 1 | Starts a recording when idle |
| cfg_short_len | input | 8 | Short bin width in frames |
| cfg_long_len | input | 8 | Long bin width in frames |
| cfg_short_bins | input | 8 | Number of short bins at the start of an event |
| cfg_total_bins | input | 8 | Total number of bins per event |
| rd_en | input | 1 | Removes the head entry of the FIFO |
| rd_data | output | 12 | Oldest stored bin value |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds 128 entries |
| fifo_level | output | 8 | Number of stored entries |
| overflow | output | 1 | Sticky: a bin was dropped at full |
| busy | output | 1 | An event is being recorded |

## Verification
The two functions that can meet in one cycle are the sequencer writing a closed bin and the host reading the head entry. The case that matters most is when this happens with the FIFO at exactly 128 entries. The bench fills the FIFO with one event and then confirms that a second event's bins are dropped and raise `overflow`. It then starts a third event and enables reading so that the first read lands on the same edge as the first write. The level must hold at 128 through that overlap. The scoreboard must then receive the original 128 bins followed by the third event's bins, with none of the dropped ones in between.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    // Widths shared by the datapath
    localparam int CNT_W = 8;   // per-frame summed count
    localparam int BIN_W = 12;  // stored bin value
    localparam int LEN_W = 8;   // bin width in frames
    localparam int NUM_W = 8;   // bin counters

    typedef logic [CNT_W-1:0] frame_cnt_t;
    typedef logic [BIN_W-1:0] bin_val_t;
    typedef logic [LEN_W-1:0] bin_len_t;
    typedef logic [NUM_W-1:0] bin_num_t;

    typedef struct packed {
        bin_len_t short_len;
        bin_len_t long_len;
        bin_num_t short_bins;
        bin_num_t total_bins;
    } bin_cfg_t;

    // Adds a frame count to a bin and clamps the result at all ones
    function automatic bin_val_t sat_add(input bin_val_t acc, input frame_cnt_t add);
        logic [BIN_W:0] sum;
        sum = {1'b0, acc} + {{(BIN_W + 1 - CNT_W){1'b0}}, add};
        return sum[BIN_W] ? '1 : sum[BIN_W-1:0];
    endfunction

    function automatic bin_len_t len_at_least_one(input bin_len_t v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

    function automatic bin_num_t num_at_least_one(input bin_num_t v);
        return (v == '0) ? NUM_W'(1) : v;
    endfunction

endpackage

// File: rtl/pbf_sequencer.sv
module pbf_sequencer
    import pbf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     event_start,
    input  bin_cfg_t cfg_in,
    output logic     active,
    output logic     bin_done
);

    bin_cfg_t cfg_q;
    bin_len_t frame_idx;
    bin_num_t bin_idx;
    bin_len_t cur_len;
    logic     last_bin;

    // Width of the open bin: short phase first, long afterwards
    always_comb begin
        cur_len  = (bin_idx < cfg_q.short_bins) ? cfg_q.short_len : cfg_q.long_len;
        bin_done = active && (frame_idx == cur_len - LEN_W'(1));
        last_bin = (bin_idx == cfg_q.total_bins - NUM_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cfg_q     <= '0;
            frame_idx <= '0;
            bin_idx   <= '0;
        end else if (!active) begin
            frame_idx <= '0;
            bin_idx   <= '0;
            if (event_start) begin
                active <= 1'b1;
                cfg_q  <= '{short_len:  len_at_least_one(cfg_in.short_len),
                            long_len:   len_at_least_one(cfg_in.long_len),
                            short_bins: cfg_in.short_bins,
                            total_bins: num_at_least_one(cfg_in.total_bins)};
            end
        end else if (bin_done) begin
            frame_idx <= '0;
            bin_idx   <= bin_idx + NUM_W'(1);
            if (last_bin) begin
                active <= 1'b0;
            end
        end else begin
            frame_idx <= frame_idx + LEN_W'(1);
        end
    end

    // R4: closing the final bin ends the event
    assert_idle_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        (bin_done && last_bin) |=> !active);

    // R7: a running event keeps its captured settings until it ends
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !(bin_done && last_bin)) |=> (active && $stable(cfg_q)));

    // R3: the frame position never passes the width of the open bin
    assert_frame_in_bin_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (frame_idx < cur_len));

endmodule

// File: rtl/pbf_accum.sv
module pbf_accum
    import pbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       close,
    input  frame_cnt_t frame_in,
    output bin_val_t   bin_value
);

    bin_val_t acc;

    // Value of the bin including the current frame
    assign bin_value = sat_add(acc, frame_in);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc <= '0;
        end else if (close) begin
            acc <= '0;
        end else begin
            acc <= bin_value;
        end
    end

    // R6: within a bin the running sum never wraps back down
    assert_acc_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !close) |=> (acc >= $past(acc)));

endmodule

// File: rtl/pbf_fifo.sv
module pbf_fifo #(
    parameter  int DEPTH = 128,
    parameter  int W     = 12,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level,
    output logic          overflow
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          do_pop;
    logic          do_push;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            if (do_push && !do_pop) begin
                level <= level + LW'(1);
            end else if (do_pop && !do_push) begin
                level <= level - LW'(1);
            end
            if (push && !do_push) begin
                overflow <= 1'b1;
            end
        end
    end

    // R8: occupancy stays within the storage
    assert_level_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R8: a read of an empty FIFO with no write leaves it empty
    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

    // R9: a write at full with no read is dropped and flagged
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && overflow));

    // R9: simultaneous write and read at full keep it full
    assert_pushpop_full_R9: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full) |=> full);

    // R9: the loss flag is sticky
    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: rtl/pulse_bin_fifo.sv
module pulse_bin_fifo
    import pbf_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] frame_count,
    input  logic             event_start,
    input  logic [LEN_W-1:0] cfg_short_len,
    input  logic [LEN_W-1:0] cfg_long_len,
    input  logic [NUM_W-1:0] cfg_short_bins,
    input  logic [NUM_W-1:0] cfg_total_bins,
    input  logic             rd_en,
    output logic [BIN_W-1:0] rd_data,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic [LVL_W-1:0] fifo_level,
    output logic             overflow,
    output logic             busy
);

    bin_cfg_t cfg_in;
    logic     bin_done;
    bin_val_t bin_value;

    assign cfg_in = '{short_len:  cfg_short_len,
                      long_len:   cfg_long_len,
                      short_bins: cfg_short_bins,
                      total_bins: cfg_total_bins};

    pbf_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .event_start (event_start),
        .cfg_in      (cfg_in),
        .active      (busy),
        .bin_done    (bin_done)
    );

    pbf_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (busy),
        .close     (bin_done),
        .frame_in  (frame_count),
        .bin_value (bin_value)
    );

    pbf_fifo #(
        .DEPTH (DEPTH),
        .W     (BIN_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (bin_done),
        .push_data (bin_value),
        .pop       (rd_en),
        .head      (rd_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_level),
        .overflow  (overflow)
    );

endmodule

// File: tb/pulse_bin_fifo_bench.sv
module pulse_bin_fifo_bench;
    import pbf_pkg::*;

    localparam int DEPTH = 128;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] frame_count = '0;
    logic             event_start = 1'b0;
    logic [LEN_W-1:0] cfg_short_len = '0;
    logic [LEN_W-1:0] cfg_long_len = '0;
    logic [NUM_W-1:0] cfg_short_bins = '0;
    logic [NUM_W-1:0] cfg_total_bins = '0;
    logic             rd_en = 1'b0;
    logic [BIN_W-1:0] rd_data;
    logic             fifo_empty;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             overflow;
    logic             busy;

    always #5 clk = ~clk;

    pulse_bin_fifo #(.DEPTH(DEPTH)) u_pulse_bin_fifo (
        .clk            (clk),
        .rst            (rst),
        .frame_count    (frame_count),
        .event_start    (event_start),
        .cfg_short_len  (cfg_short_len),
        .cfg_long_len   (cfg_long_len),
        .cfg_short_bins (cfg_short_bins),
        .cfg_total_bins (cfg_total_bins),
        .rd_en          (rd_en),
        .rd_data        (rd_data),
        .fifo_empty     (fifo_empty),
        .fifo_full      (fifo_full),
        .fifo_level     (fifo_level),
        .overflow       (overflow),
        .busy           (busy)
    );

    int       checks = 0;
    int       errors = 0;
    bit       mon_en = 1'b0;
    bit       done   = 1'b0;
    bin_val_t exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic int fval(input int kind, input int i);
        case (kind)
            0:       return (i * 7 + 3) % 256;
            1:       return 255;
            default: return i % 5;
        endcase
    endfunction

    // Monitor: pops whenever enabled and data waits, compares with the scoreboard (R2, R8)
    always @(negedge clk) begin
        rd_en = 1'b0;
        if (!rst && mon_en && !fifo_empty) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", int'(rd_data), -1, "unexpected bin in FIFO");
            end else begin
                bin_val_t e;
                e = exp_q.pop_front();
                check(rd_data == e, "R2", int'(rd_data), int'(e), "bin value in order");
            end
            rd_en = 1'b1;
        end
    end

    // Driver: computes expected bins from the requirements, then plays the frames
    task automatic run_event(input int sl, input int ll, input int sb, input int tb, input int kind,
                             input bit store, input bit disturb, input bit mon_at_start);
        int esl = (sl == 0) ? 1 : sl;        // R5
        int ell = (ll == 0) ? 1 : ll;
        int etb = (tb == 0) ? 1 : tb;
        int nfr = 0;
        for (int b = 0; b < etb; b++) begin
            int w = (b < sb) ? esl : ell;      // R3
            int s = 0;
            for (int f = 0; f < w; f++) begin
                s += fval(kind, nfr);
                nfr++;
            end
            if (s > 4095) s = 4095;            // R6
            if (store) exp_q.push_back(BIN_W'(s));
        end
        @(negedge clk);
        cfg_short_len  = LEN_W'(sl);
        cfg_long_len   = LEN_W'(ll);
        cfg_short_bins = NUM_W'(sb);
        cfg_total_bins = NUM_W'(tb);
        event_start    = 1'b1;
        frame_count    = 8'd200;               // R1: not part of any bin
        if (mon_at_start) begin
            @(posedge clk);
            mon_en = 1'b1;
        end
        for (int i = 0; i < nfr; i++) begin
            @(negedge clk);
            frame_count = CNT_W'(fval(kind, i));
            event_start = 1'b0;
            if (i == 0) check(busy == 1'b1, "R1", int'(busy), 1, "busy after start");
            if (disturb && i == 1) begin       // R7: ignored mid-event changes
                cfg_short_len  = 8'd9;
                cfg_long_len   = 8'd1;
                cfg_short_bins = 8'd0;
                cfg_total_bins = 8'd1;
                event_start    = 1'b1;
            end
            if (mon_at_start && i == 3)
                check(fifo_level == LVL_W'(DEPTH), "R9", int'(fifo_level), DEPTH, "level during write+read at full");
        end
        @(negedge clk);
        event_start = 1'b0;
        check(busy == 1'b0, "R4", int'(busy), 0, "idle after last bin");
        frame_count = 8'd77;                   // R4: must not be recorded
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R4", int'(busy), 0, "stays idle with frames present");
        frame_count = '0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        mon_en = 1'b1;
        while ((exp_q.size() != 0 || !fifo_empty) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0, "scoreboard drained");
        check(fifo_empty == 1'b1, req, int'(fifo_empty), 1, "FIFO empty after drain");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R10", int'(busy), 0, "busy after reset");
        check(fifo_empty == 1'b1, "R10", int'(fifo_empty), 1, "empty after reset");
        check(fifo_full == 1'b0, "R10", int'(fifo_full), 0, "full after reset");
        check(fifo_level == '0, "R10", int'(fifo_level), 0, "level after reset");
        check(overflow == 1'b0, "R10", int'(overflow), 0, "overflow after reset");

        mon_en = 1'b1;
        run_event(2, 5, 3, 6, 0, 1'b1, 1'b0, 1'b0);   // R2 R3 mixed widths
        drain("R2");
        run_event(3, 4, 0, 3, 2, 1'b1, 1'b0, 1'b0);   // R3 all long
        drain("R3");
        run_event(2, 9, 10, 4, 0, 1'b1, 1'b0, 1'b0);  // R3 all short
        drain("R3");
        run_event(0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b0);   // R5 zero settings
        drain("R5");
        run_event(20, 1, 1, 2, 1, 1'b1, 1'b0, 1'b0);  // R6 saturation
        drain("R6");
        run_event(3, 6, 2, 5, 0, 1'b1, 1'b1, 1'b0);   // R7 mid-event changes
        drain("R7");

        // R8 fill to full without reading
        mon_en = 1'b0;
        run_event(1, 1, 0, 128, 0, 1'b1, 1'b0, 1'b0);
        check(fifo_full == 1'b1, "R8", int'(fifo_full), 1, "full after 128 bins");
        check(fifo_level == LVL_W'(DEPTH), "R8", int'(fifo_level), DEPTH, "level at full");
        check(overflow == 1'b0, "R8", int'(overflow), 0, "no loss while filling");
        // R9 writes at full are dropped
        run_event(1, 1, 0, 3, 2, 1'b0, 1'b0, 1'b0);
        check(overflow == 1'b1, "R9", int'(overflow), 1, "overflow after drop");
        check(fifo_level == LVL_W'(DEPTH), "R9", int'(fifo_level), DEPTH, "level unchanged by drop");
        // R9 write and read on the same edge at full
        run_event(1, 1, 0, 10, 0, 1'b1, 1'b0, 1'b1);
        drain("R9");
        check(overflow == 1'b1, "R9", int'(overflow), 1, "overflow sticky");

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule